// File: doc/BRIEF.md
# Saturating Integer Multiplier

This block multiplies two W-bit integers and returns a W-bit result that clamps to the nearest representable extreme instead of wrapping. A single mode input chooses whether the operands and the result are read as unsigned or as two's complement. The output is purely combinational, with no clock and no state.

The full 2W-bit product is never built. A truncated array of partial products forms only the low W+1 bits of the product. In parallel, an overflow detector looks at the operands themselves. It finds the position of the highest significant bit of each operand. For an unsigned operand this is the leading one. For a signed operand it is the leading bit that differs from the sign. The sum of the two positions classifies almost every operand pair as safe or as overflowing. Only a narrow band of pairs is left undecided, and the top one or two bits of the truncated product settle those. When overflow is found, a small output mux replaces the product with the correct saturation value.

Top module: `sat_mul`

## Requirements
- R1: In unsigned mode (`sgn_mode`=0), when a*b < 2^W the result equals a*b and `ovf` is 0.
- R2: In unsigned mode, when a*b >= 2^W the result is 2^W-1 (all ones) and `ovf` is 1.
- R3: In signed mode (`sgn_mode`=1), when the true product lies in [-2^(W-1), 2^(W-1)-1] the result is that product in two's complement and `ovf` is 0.
- R4: In signed mode, a product above 2^(W-1)-1 gives a result of 2^(W-1)-1 (MSB 0, all other bits 1) and `ovf` = 1.
- R5: In signed mode, a product below -2^(W-1) gives a result of -2^(W-1) (MSB 1, all other bits 0) and `ovf` = 1.
- R6: If either operand is zero, the result is zero and `ovf` is 0, in both modes.
- R7: In signed mode, -2^(W-1) times -1 is flagged as overflow and saturates to 2^(W-1)-1.
- R8: In signed mode, a product equal to exactly -2^(W-1) is not flagged and is returned unchanged.
- R9: In unsigned mode, the boundary is exact: a product of 2^W-1 passes through unflagged, and a product of 2^W is flagged.

Top module parameter: `W` (operand and result width, default 16, at least 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Multiplicand |
| b | input | W | Multiplier |
| sgn_mode | input | 1 | 1 = two's complement operands and result, 0 = unsigned |
| prod | output | W | Product, saturated on overflow |
| ovf | output | 1 | High when the true product does not fit in W bits |

## Verification
The hardest cases lie where the two leading-bit positions sum to W-1 or W-2. Only the top truncated product bits decide these. A detector that misreads those bits would either let a wrapped value through or clamp a product that fits, and R9 and R8 test both edges of that band. Operand pairs that include -1 or -2^(W-1) test the leading-non-sign-bit encoder, which gives a degenerate position for these values. If the sign of the product is taken wrongly, -2^(W-1) times -1 (R7) would clamp negative. Zero operands test that the flag is gated. Every operand pair of a 4-bit instance is applied in both modes. A 16-bit instance is driven with magnitude-spread random operands, so that both sides of the boundary band are hit many times.

// File: rtl/sat_mul_pkg.sv
// Shared types for the saturating multiplier.
// Assumes: consumers decode sat_kind_e only through the names below.
package sat_mul_pkg;

    // Which clamp value, if any, the output stage must apply.
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_UMAX = 2'd1,
        SAT_SMAX = 2'd2,
        SAT_SMIN = 2'd3
    } sat_kind_e;

endpackage

// File: rtl/sm_lead_pos.sv
// Leading-one position encoder.
// Returns the index of the highest set bit of vec; returns 0 when vec is 0.
// Assumes: IW is wide enough to hold W-1.
module sm_lead_pos #(
    parameter int W  = 16,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] pos
);

    // Scan upward so the highest set bit is the last one written.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = IW'(i);
        end
    end

    // R6 support: a zero vector reports position 0.
    always_comb begin
        if (!$isunknown(vec)) begin
            a_r6_zero_pos: assert ((vec != '0) || (pos == '0))
                else $error("lead_pos nonzero for zero vector");
            a_r1_pos_bit_set: assert ((vec == '0) || vec[pos])
                else $error("lead_pos points at a clear bit");
        end
    end

endmodule

// File: rtl/sm_trunc_array.sv
// Truncated array multiplier: only the low W+1 bits of a*b.
// Each operand is extended to W+1 bits (sign or zero per mode). The
// partial-product rows are then summed modulo 2^(W+1), which gives the
// exact low bits in both modes.
// Assumes: W >= 2.
module sm_trunc_array #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn_mode,
    output logic [W:0]   low
);

    localparam int PW = W + 1;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] row [PW];
    logic [PW-1:0] acc [PW];

    // Extend the operands to W+1 bits according to the mode.
    always_comb begin
        a_ext = {sgn_mode & a[W-1], a};
        b_ext = {sgn_mode & b[W-1], b};
    end

    // One gated, shifted row per multiplier bit, chained through adders.
    for (genvar i = 0; i < PW; i++) begin : g_row
        assign row[i] = b_ext[i] ? (a_ext << i) : '0;
        if (i == 0) begin : g_first
            assign acc[i] = row[i];
        end else begin : g_next
            assign acc[i] = acc[i-1] + row[i];
        end
    end

    assign low = acc[PW-1];

    // R1: the lowest product bit is the AND of the operand LSBs.
    always_comb begin
        if (!$isunknown({a, b, sgn_mode})) begin
            a_r1_lsb: assert (low[0] == (a[0] & b[0]))
                else $error("truncated product LSB wrong");
            a_r6_zero_rows: assert (!((a == '0) || (b == '0)) || (low == '0))
                else $error("truncated product nonzero for zero operand");
        end
    end

endmodule

// File: rtl/sm_ovf_detect.sv
// Operand-based overflow detector.
// Finds the leading significant bit position of each operand: the leading
// one in unsigned mode, or the leading bit that differs from the sign in
// signed mode. From the sum k of the two positions it classifies the pair.
// When k is too close to the width to decide, it uses the top two
// truncated product bits, and it selects the clamp value.
// Assumes: W >= 4; low_top = {product bit W, product bit W-1}.
module sm_ovf_detect
    import sat_mul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn_mode,
    input  logic [1:0]   low_top,
    output sat_kind_e    kind
);

    localparam int IW = $clog2(W);
    localparam int KW = IW + 1;
    localparam logic [KW-1:0] K_WIDE = KW'(W);
    localparam logic [KW-1:0] K_EDGE = KW'(W - 1);

    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic [IW-1:0] pos_a;
    logic [IW-1:0] pos_b;
    logic [KW-1:0] k;
    logic          any_zero;
    logic          neg_res;
    logic          u_ovf;
    logic          s_ovf;
    logic          hit;

    // Strip sign copies in signed mode so only significant bits remain.
    always_comb begin
        mag_a = sgn_mode ? (a ^ {W{a[W-1]}}) : a;
        mag_b = sgn_mode ? (b ^ {W{b[W-1]}}) : b;
    end

    sm_lead_pos #(.W(W), .IW(IW)) u_pos_a (.vec(mag_a), .pos(pos_a));
    sm_lead_pos #(.W(W), .IW(IW)) u_pos_b (.vec(mag_b), .pos(pos_b));

    // Classify the operand pair from the position sum and the boundary bits.
    always_comb begin
        k        = KW'(pos_a) + KW'(pos_b);
        any_zero = (a == '0) || (b == '0);
        neg_res  = sgn_mode & (a[W-1] ^ b[W-1]);
        u_ovf    = (k >= K_WIDE) || ((k == K_EDGE) && low_top[1]);
        s_ovf    = (k >= K_WIDE)
                 || ((k == K_EDGE) && !(neg_res && low_top[1] && low_top[0]))
                 || ((k < K_EDGE) && (low_top[1] != low_top[0]));
        hit      = !any_zero && (sgn_mode ? s_ovf : u_ovf);
    end

    // Choose the clamp value from the mode and the sign of the true product.
    always_comb begin
        if (!hit)           kind = SAT_NONE;
        else if (!sgn_mode) kind = SAT_UMAX;
        else if (neg_res)   kind = SAT_SMIN;
        else                kind = SAT_SMAX;
    end

    // Guards on the detector's decisions.
    always_comb begin
        if (!$isunknown({a, b, sgn_mode, low_top})) begin
            a_r6_no_overflow: assert (!any_zero || (kind == SAT_NONE))
                else $error("overflow flagged with a zero operand");
            a_r2_wide_sum: assert (any_zero || (k < K_WIDE) || (kind != SAT_NONE))
                else $error("wide position sum not flagged");
            a_r7_min_times_m1: assert (!(sgn_mode && (a == {1'b1, {(W-1){1'b0}}})
                                         && (b == '1)) || (kind == SAT_SMAX))
                else $error("most negative times -1 not clamped positive");
        end
    end

endmodule

// File: rtl/sat_mul.sv
// Saturating W-bit integer multiplier, unsigned or two's complement.
// Forms only W+1 product bits. The overflow decision comes from the
// operand-based detector, which runs beside the array, and a final mux
// substitutes the clamp value. Purely combinational.
// Assumes: W >= 4.
module sat_mul
    import sat_mul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn_mode,
    output logic [W-1:0] prod,
    output logic         ovf
);

    localparam logic [W-1:0] V_UMAX = '1;
    localparam logic [W-1:0] V_SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] V_SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] low;
    sat_kind_e  kind;

    sm_trunc_array #(.W(W)) u_array (
        .a(a), .b(b), .sgn_mode(sgn_mode), .low(low)
    );

    sm_ovf_detect #(.W(W)) u_detect (
        .a(a), .b(b), .sgn_mode(sgn_mode),
        .low_top(low[W:W-1]), .kind(kind)
    );

    // Output mux: pass the truncated product or the selected clamp value.
    always_comb begin
        ovf = (kind != SAT_NONE);
        unique case (kind)
            SAT_UMAX: prod = V_UMAX;
            SAT_SMAX: prod = V_SMAX;
            SAT_SMIN: prod = V_SMIN;
            default:  prod = low[W-1:0];
        endcase
    end

    // Guards on the relation between inputs, flag and result.
    always_comb begin
        if (!$isunknown({a, b, sgn_mode})) begin
            a_r2_umax: assert (!(ovf && !sgn_mode) || (prod == V_UMAX))
                else $error("unsigned overflow not clamped to all ones");
            a_r4_r5_sclamp: assert (!(ovf && sgn_mode)
                                    || (prod == V_SMAX) || (prod == V_SMIN))
                else $error("signed overflow not clamped to an extreme");
            a_r6_zero_out: assert (!((a == '0) || (b == '0)) || (!ovf && (prod == '0)))
                else $error("zero operand gave nonzero result or flag");
            a_r3_pass: assert (ovf || (prod == low[W-1:0]))
                else $error("unflagged result differs from truncated product");
        end
    end

endmodule

// File: tb/sim_sat_mul.sv
`timescale 1ns/1ps
// Scoreboard bench: drives a 16-bit instance (u0) and a 4-bit instance (u1).
module sim_sat_mul;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0] a0, b0, p0;
    logic        s0, o0;
    logic [3:0]  a1, b1, p1;
    logic        s1, o1;

    sat_mul #(.W(16)) u0 (.a(a0), .b(b0), .sgn_mode(s0), .prod(p0), .ovf(o0));
    sat_mul #(.W(4))  u1 (.a(a1), .b(b1), .sgn_mode(s1), .prod(p1), .ovf(o1));

    bit          q_sel [$];
    logic [15:0] q_p   [$];
    logic        q_o   [$];
    string       q_tag [$];

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model on full-width integers.
    task automatic model(input int w, input logic [15:0] av, input logic [15:0] bv,
                         input bit sg, output logic [15:0] ep, output logic eo,
                         output string tag);
        longint mask, smax, smin, sa, sb, pr;
        mask = (64'sd1 <<< w) - 1;
        smax = (64'sd1 <<< (w - 1)) - 1;
        smin = -(64'sd1 <<< (w - 1));
        sa = longint'(av) & mask;
        sb = longint'(bv) & mask;
        if (sg) begin
            if (sa > smax) sa = sa - (mask + 1);
            if (sb > smax) sb = sb - (mask + 1);
        end
        pr = sa * sb;
        if (!sg) begin
            eo  = (pr > mask);
            ep  = eo ? 16'(mask) : 16'(pr);
            tag = eo ? "R2" : "R1";
        end else if (pr > smax) begin
            eo = 1'b1; ep = 16'(smax); tag = "R4";
        end else if (pr < smin) begin
            eo = 1'b1; ep = 16'(smin & mask); tag = "R5";
        end else begin
            eo = 1'b0; ep = 16'(pr & mask); tag = "R3";
        end
        if (sa == 0 || sb == 0) tag = "R6";
    endtask

    // Driver: apply one vector after a falling edge and queue its expectation.
    task automatic drive(input bit sel, input logic [15:0] av, input logic [15:0] bv,
                         input bit sg, input string force_tag);
        logic [15:0] ep;
        logic        eo;
        string       tag;
        model(sel ? 4 : 16, av, bv, sg, ep, eo, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        if (sel) begin a1 = av[3:0]; b1 = bv[3:0]; s1 = sg; end
        else     begin a0 = av;      b0 = bv;      s0 = sg; end
        q_sel.push_back(sel);
        q_p.push_back(ep);
        q_o.push_back(eo);
        q_tag.push_back(tag);
    endtask

    // Monitor: at each rising edge compare the oldest pending expectation.
    always @(posedge clk) begin
        if (q_sel.size() > 0) begin
            bit          sel;
            logic [15:0] ep, gp;
            logic        eo, go;
            string       tag;
            sel = q_sel.pop_front();
            ep  = q_p.pop_front();
            eo  = q_o.pop_front();
            tag = q_tag.pop_front();
            gp  = sel ? {12'd0, p1} : p0;
            go  = sel ? o1 : o0;
            n_vec++;
            if (gp !== ep || go !== eo) begin
                n_fail++;
                $display("FAIL %s w=%0d: prod=%h ovf=%b, expected prod=%h ovf=%b",
                         tag, sel ? 4 : 16, gp, go, ep, eo);
            end
        end
    end

    function automatic logic [15:0] spread();
        logic [15:0] v;
        v = 16'($urandom) & 16'((32'd1 << ($urandom % 17)) - 1);
        if ($urandom % 3 == 0) v = ~v;
        return v;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        a0 = '0; b0 = '0; s0 = 1'b0;
        a1 = '0; b1 = '0; s1 = 1'b0;
        // Directed 16-bit corners.
        drive(0, 16'd0,     16'hFFFF, 0, "R6");
        drive(0, 16'h8000,  16'd0,    1, "R6");
        drive(0, 16'd255,   16'd257,  0, "R9");
        drive(0, 16'd256,   16'd256,  0, "R9");
        drive(0, 16'd300,   16'd200,  0, "R1");
        drive(0, 16'hFFFF,  16'hFFFF, 0, "R2");
        drive(0, 16'h8000,  16'hFFFF, 1, "R7");
        drive(0, 16'hC000,  16'd2,    1, "R8");
        drive(0, 16'd2,     16'hC000, 1, "R8");
        drive(0, 16'd181,   16'd181,  1, "R3");
        drive(0, 16'd182,   16'd181,  1, "R4");
        drive(0, 16'hFF4B,  16'd182,  1, "R5");
        drive(0, 16'hC000,  16'hFFFE, 1, "R4");
        drive(0, 16'h8000,  16'd1,    1, "R8");
        drive(0, 16'hFFFF,  16'hFFFF, 1, "R3");
        // Exhaustive 4-bit, both modes.
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    drive(1, 16'(i), 16'(j), m[0], "");
        // Random 16-bit with spread magnitudes, both modes.
        for (int n = 0; n < 4000; n++)
            drive(0, spread(), spread(), n[0], "");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule